// File: doc/BRIEF.md
# Direct-Page Effective Address Generator

This unit turns an operand addressing mode and its operand fields into the 16-bit effective address used by an 8-bit CPU core. It has a 256-byte direct page whose base is selected by one status bit: page 0x0000 when the bit is clear, page 0x0100 when it is set. It covers direct-page, direct-page-indexed, register-indirect, post-incrementing register-indirect, absolute, absolute-indexed, pre-indexed pointer and post-indexed pointer modes. For the two pointer modes it reads the two pointer bytes itself over a plain synchronous read port.

The request side is a valid/ready handshake. A request moves on the rising edge where `req_valid` and `req_ready` are both high, and all operand fields and index registers are captured on that edge. While a pointer fetch is in progress, `req_ready` stays low. This is the only back-pressure, and a held `req_valid` simply waits. The result side cannot be stalled. `done` is high for exactly one cycle per accepted request, and `ea` and `x_inc` are valid only while `done` is high. Requests for the direct modes can follow each other on consecutive cycles.

Top module: `dpea_gen`

## Requirements
- R1: `req_ready` is high whenever no pointer fetch is in progress. It falls in the cycle after a pointer-mode request is accepted and stays low until the cycle in which that request's `done` is high.
- R2: Mode 0 (direct page) gives {7'b0, page_sel, ofs}. Mode 1 (page + X) and mode 2 (page + Y) give {7'b0, page_sel, (ofs + index) mod 256}. For every non-pointer mode, `done` is high in the cycle after acceptance.
- R3: Mode 3 gives {7'b0, page_sel, X} and mode 4 gives {7'b0, page_sel, Y}.
- R4: Mode 5 gives {7'b0, page_sel, X} with `x_inc` high together with `done`. `x_inc` is low with every other mode's `done` and whenever `done` is low.
- R5: Mode 6 gives `req_abs`. Mode 7 and mode 8 give (`req_abs` + X) mod 65536 and (`req_abs` + Y) mod 65536.
- R6: Mode 9 (index before pointer) reads the low pointer byte at {7'b0, page_sel, (ofs+X) mod 256} and the high byte at {7'b0, page_sel, (ofs+X+1) mod 256}, on two consecutive `rd_en` cycles. The result is {high, low}.
- R7: Mode 10 (index after pointer) reads the low byte at {7'b0, page_sel, ofs} and the high byte at {7'b0, page_sel, (ofs+1) mod 256}. The result is ({high, low} + Y) mod 65536.
- R8: In the pointer modes, `rd_en` is high in the two cycles after acceptance and `rd_data` is taken one cycle after each read. `done` is high four cycles after acceptance.
- R9: Unused mode codes 11 to 15 behave as mode 0.
- R10: During and right after reset, `done`, `x_inc` and `rd_en` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_mode | input | 4 | Addressing mode code |
| req_ofs | input | 8 | Direct-page offset operand |
| req_abs | input | 16 | Absolute address operand |
| idx_x | input | 8 | X index register value |
| idx_y | input | 8 | Y index register value |
| page_sel | input | 1 | Direct-page select bit |
| rd_en | output | 1 | Pointer byte read strobe |
| rd_addr | output | 16 | Pointer byte read address |
| rd_data | input | 8 | Read data, one cycle after `rd_en` |
| ea | output | 16 | Effective address, valid with `done` |
| done | output | 1 | One-cycle result strobe |
| x_inc | output | 1 | Request to increment X, valid with `done` |

## Verification
The assertions rely on the read port returning its byte exactly one cycle after each `rd_en`. They also rely on the operand fields mattering only on the accepting edge. The bench's memory model answers every read one cycle later with a byte computed from the address. The driver changes the request fields only on falling edges and drops `req_valid` while the unit is busy. Mode codes, offsets near 0xFF, absolute values near 0xFFFF and both page settings are chosen so that every wrap appears, both in the directed cases and in the random ones.

// File: rtl/dpea_pkg.sv
package dpea_pkg;

  typedef enum logic [3:0] {
    AM_DP       = 4'd0,
    AM_DP_X     = 4'd1,
    AM_DP_Y     = 4'd2,
    AM_REG_X    = 4'd3,
    AM_REG_Y    = 4'd4,
    AM_REG_XINC = 4'd5,
    AM_ABS      = 4'd6,
    AM_ABS_X    = 4'd7,
    AM_ABS_Y    = 4'd8,
    AM_PTR_PRE  = 4'd9,
    AM_PTR_POST = 4'd10
  } amode_e;

  typedef enum logic [1:0] {
    FS_IDLE,
    FS_LO,
    FS_HI,
    FS_FIN
  } fstate_e;

  function automatic logic is_ptr_mode(input logic [3:0] m);
    return (m == AM_PTR_PRE) || (m == AM_PTR_POST);
  endfunction

endpackage

// File: rtl/dpea_page_map.sv
module dpea_page_map #(
  parameter int OFS_W = 8
) (
  input  logic                   page_sel,
  input  logic [OFS_W-1:0]       ofs,
  output logic [2*OFS_W-1:0]     addr
);
  localparam int ADDR_W = 2 * OFS_W;
  localparam int PAD_W  = ADDR_W - OFS_W - 1;

  assign addr = {{PAD_W{1'b0}}, page_sel, ofs};

endmodule

// File: rtl/dpea_direct.sv
module dpea_direct
  import dpea_pkg::*;
#(
  parameter int OFS_W = 8
) (
  input  logic [3:0]            mode,
  input  logic                  page_sel,
  input  logic [OFS_W-1:0]      ofs,
  input  logic [2*OFS_W-1:0]    abs_addr,
  input  logic [OFS_W-1:0]      ix,
  input  logic [OFS_W-1:0]      iy,
  output logic [2*OFS_W-1:0]    ea,
  output logic                  xinc
);
  localparam int ADDR_W = 2 * OFS_W;

  logic [OFS_W-1:0]  page_ofs;
  logic [ADDR_W-1:0] page_addr;
  logic [ADDR_W-1:0] abs_sum;
  logic              use_abs;

  always_comb begin
    page_ofs = ofs;
    use_abs  = 1'b0;
    xinc     = 1'b0;
    abs_sum  = abs_addr;
    case (mode)
      AM_DP_X:     page_ofs = ofs + ix;
      AM_DP_Y:     page_ofs = ofs + iy;
      AM_REG_X:    page_ofs = ix;
      AM_REG_Y:    page_ofs = iy;
      AM_REG_XINC: begin
        page_ofs = ix;
        xinc     = 1'b1;
      end
      AM_ABS:      use_abs = 1'b1;
      AM_ABS_X: begin
        use_abs = 1'b1;
        abs_sum = abs_addr + ADDR_W'(ix);
      end
      AM_ABS_Y: begin
        use_abs = 1'b1;
        abs_sum = abs_addr + ADDR_W'(iy);
      end
      default:     page_ofs = ofs;
    endcase
  end

  dpea_page_map #(.OFS_W(OFS_W)) u_map (
    .page_sel (page_sel),
    .ofs      (page_ofs),
    .addr     (page_addr)
  );

  assign ea = use_abs ? abs_sum : page_addr;

endmodule

// File: rtl/dpea_ptr_fetch.sv
module dpea_ptr_fetch
  import dpea_pkg::*;
#(
  parameter int OFS_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  page_sel,
  input  logic [OFS_W-1:0]      ptr_ofs,
  input  logic [OFS_W-1:0]      post_add,
  output logic                  rd_en,
  output logic [2*OFS_W-1:0]    rd_addr,
  input  logic [OFS_W-1:0]      rd_data,
  output logic                  busy,
  output logic                  fin,
  output logic [2*OFS_W-1:0]    fea
);
  localparam int ADDR_W = 2 * OFS_W;

  fstate_e          st;
  logic [OFS_W-1:0] ptr_q;
  logic [OFS_W-1:0] add_q;
  logic [OFS_W-1:0] lo_q;
  logic             page_q;
  logic [OFS_W-1:0] cur_ofs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= FS_IDLE;
      ptr_q  <= '0;
      add_q  <= '0;
      lo_q   <= '0;
      page_q <= 1'b0;
    end else begin
      case (st)
        FS_IDLE: if (start) begin
          st     <= FS_LO;
          ptr_q  <= ptr_ofs;
          add_q  <= post_add;
          page_q <= page_sel;
        end
        FS_LO:   st <= FS_HI;
        FS_HI: begin
          lo_q <= rd_data;
          st   <= FS_FIN;
        end
        default: st <= FS_IDLE;
      endcase
    end
  end

  assign rd_en   = (st == FS_LO) || (st == FS_HI);
  assign cur_ofs = (st == FS_HI) ? ptr_q + 1'b1 : ptr_q;
  assign busy    = (st != FS_IDLE);
  assign fin     = (st == FS_FIN);
  assign fea     = {rd_data, lo_q} + ADDR_W'(add_q);

  dpea_page_map #(.OFS_W(OFS_W)) u_map (
    .page_sel (page_q),
    .ofs      (cur_ofs),
    .addr     (rd_addr)
  );

  // R6/R7: high-byte read follows low-byte read at the next offset in the page
  p_rd_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && st == FS_LO) |=> (rd_en &&
      rd_addr[OFS_W-1:0] == OFS_W'($past(rd_addr[OFS_W-1:0]) + 1'b1) &&
      rd_addr[ADDR_W-1:OFS_W] == $past(rd_addr[ADDR_W-1:OFS_W])));

  // R6: pointer reads never leave the selected direct page
  p_rd_page_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (rd_addr[ADDR_W-1:OFS_W+1] == '0));

endmodule

// File: rtl/dpea_gen.sv
module dpea_gen
  import dpea_pkg::*;
#(
  parameter int OFS_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [3:0]            req_mode,
  input  logic [OFS_W-1:0]      req_ofs,
  input  logic [2*OFS_W-1:0]    req_abs,
  input  logic [OFS_W-1:0]      idx_x,
  input  logic [OFS_W-1:0]      idx_y,
  input  logic                  page_sel,
  output logic                  rd_en,
  output logic [2*OFS_W-1:0]    rd_addr,
  input  logic [OFS_W-1:0]      rd_data,
  output logic [2*OFS_W-1:0]    ea,
  output logic                  done,
  output logic                  x_inc
);
  localparam int ADDR_W = 2 * OFS_W;

  logic              accept;
  logic              ptr_mode;
  logic [ADDR_W-1:0] d_ea;
  logic              d_xinc;
  logic [OFS_W-1:0]  ptr_ofs;
  logic [OFS_W-1:0]  post_add;
  logic              f_busy;
  logic              f_fin;
  logic [ADDR_W-1:0] f_ea;
  logic [ADDR_W-1:0] ea_q;
  logic              done_q;
  logic              xinc_q;

  assign ptr_mode = is_ptr_mode(req_mode);
  assign accept   = req_valid && req_ready;
  assign ptr_ofs  = (req_mode == AM_PTR_PRE)  ? req_ofs + idx_x : req_ofs;
  assign post_add = (req_mode == AM_PTR_POST) ? idx_y : '0;

  dpea_direct #(.OFS_W(OFS_W)) u_direct (
    .mode     (req_mode),
    .page_sel (page_sel),
    .ofs      (req_ofs),
    .abs_addr (req_abs),
    .ix       (idx_x),
    .iy       (idx_y),
    .ea       (d_ea),
    .xinc     (d_xinc)
  );

  dpea_ptr_fetch #(.OFS_W(OFS_W)) u_fetch (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept && ptr_mode),
    .page_sel (page_sel),
    .ptr_ofs  (ptr_ofs),
    .post_add (post_add),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .busy     (f_busy),
    .fin      (f_fin),
    .fea      (f_ea)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ea_q   <= '0;
      done_q <= 1'b0;
      xinc_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      xinc_q <= 1'b0;
      if (accept && !ptr_mode) begin
        ea_q   <= d_ea;
        done_q <= 1'b1;
        xinc_q <= d_xinc;
      end else if (f_fin) begin
        ea_q   <= f_ea;
        done_q <= 1'b1;
      end
    end
  end

  assign req_ready = !f_busy;
  assign ea        = ea_q;
  assign done      = done_q;
  assign x_inc     = xinc_q;

  // R1: a pointer-mode request closes the request side on the next cycle
  p_busy_after_ptr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && ptr_mode) |=> !req_ready);

  // R2: non-pointer requests complete one cycle after acceptance
  p_direct_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !ptr_mode) |=> done);

  // R4: the increment request only accompanies a result
  p_xinc_with_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    x_inc |-> done);

  // R8: a fetch delivers its result three cycles after the request side closes
  p_fetch_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_ready) |-> ##3 (done && req_ready));

endmodule

// File: tb/dpea_gen_tb.sv
module dpea_gen_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_mode = '0;
  logic [7:0]  req_ofs = '0;
  logic [15:0] req_abs = '0;
  logic [7:0]  idx_x = '0;
  logic [7:0]  idx_y = '0;
  logic        page_sel = 1'b0;
  logic        rd_en;
  logic [15:0] rd_addr;
  logic [7:0]  rd_data = '0;
  logic [15:0] ea;
  logic        done;
  logic        x_inc;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  typedef struct {
    logic [15:0] ea;
    logic        xinc;
    int          at;
    string       tag;
  } exp_t;

  typedef struct {
    logic [15:0] addr;
    string       tag;
  } rd_t;

  exp_t exq[$];
  rd_t  rdq[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dpea_gen u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_ofs(req_ofs), .req_abs(req_abs),
    .idx_x(idx_x), .idx_y(idx_y), .page_sel(page_sel),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .ea(ea), .done(done), .x_inc(x_inc)
  );

  function automatic logic [7:0] mval(input logic [15:0] a);
    logic [7:0] t;
    t = a[7:0] * 8'd29;
    return t ^ a[15:8] ^ 8'h5A;
  endfunction

  always @(posedge clk) if (rd_en) rd_data <= mval(rd_addr);

  function automatic logic [15:0] pg(input logic p, input logic [7:0] o);
    return {7'b0, p, o};
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic send(input logic [3:0] m, input logic [7:0] o, input logic [15:0] a,
                      input logic [7:0] x, input logic [7:0] y, input logic p);
    exp_t e;
    logic [7:0] b;
    logic [15:0] ptr;
    bit is_ptr;
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready) @(negedge clk);
    req_mode = m; req_ofs = o; req_abs = a; idx_x = x; idx_y = y; page_sel = p;
    req_valid = 1'b1;
    is_ptr = (m == 4'd9) || (m == 4'd10);
    e.xinc = (m == 4'd5);
    e.at = cyc + (is_ptr ? 4 : 1);
    case (m)
      4'd0: begin e.ea = pg(p, o); e.tag = "R2"; end
      4'd1: begin b = o + x; e.ea = pg(p, b); e.tag = "R2"; end
      4'd2: begin b = o + y; e.ea = pg(p, b); e.tag = "R2"; end
      4'd3: begin e.ea = pg(p, x); e.tag = "R3"; end
      4'd4: begin e.ea = pg(p, y); e.tag = "R3"; end
      4'd5: begin e.ea = pg(p, x); e.tag = "R4"; end
      4'd6: begin e.ea = a; e.tag = "R5"; end
      4'd7: begin e.ea = a + {8'h00, x}; e.tag = "R5"; end
      4'd8: begin e.ea = a + {8'h00, y}; e.tag = "R5"; end
      4'd9: begin
        b = o + x;
        rdq.push_back('{pg(p, b), "R6"});
        rdq.push_back('{pg(p, b + 8'd1), "R6"});
        e.ea = {mval(pg(p, b + 8'd1)), mval(pg(p, b))};
        e.tag = "R6";
      end
      4'd10: begin
        rdq.push_back('{pg(p, o), "R7"});
        rdq.push_back('{pg(p, o + 8'd1), "R7"});
        ptr = {mval(pg(p, o + 8'd1)), mval(pg(p, o))};
        e.ea = ptr + {8'h00, y};
        e.tag = "R7";
      end
      default: begin e.ea = pg(p, o); e.tag = "R9"; end
    endcase
    exq.push_back(e);
    @(posedge clk);
    if (is_ptr) begin
      @(negedge clk);
      req_valid = 1'b0;
      check(req_ready == 1'b0, "R1", "ready during fetch", {31'b0, req_ready}, 32'h0);
    end
  endtask

  // monitor: compares results and pointer reads against the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_en) begin
        if (rdq.size() == 0) check(1'b0, "R8", "unexpected read", {16'b0, rd_addr}, 32'h0);
        else begin
          rd_t r;
          r = rdq.pop_front();
          check(rd_addr == r.addr, r.tag, "read address", {16'b0, rd_addr}, {16'b0, r.addr});
        end
      end
      if (!done) begin
        if (x_inc) check(1'b0, "R4", "x_inc without done", 32'h1, 32'h0);
      end else if (exq.size() == 0) begin
        check(1'b0, "R2", "unexpected done", {16'b0, ea}, 32'h0);
      end else begin
        exp_t e;
        e = exq.pop_front();
        check(ea == e.ea, e.tag, "address", {16'b0, ea}, {16'b0, e.ea});
        check(x_inc == e.xinc, "R4", "x_inc", {31'b0, x_inc}, {31'b0, e.xinc});
        check(cyc == e.at, (e.at - cyc) > 0 ? "R8" : e.tag, "done cycle", cyc, e.at);
      end
    end
  end

  task automatic finish_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R10: reset state
    repeat (3) @(negedge clk);
    check(!done && !x_inc && !rd_en && req_ready, "R10", "reset outputs",
          {28'b0, done, x_inc, rd_en, req_ready}, 32'h1);
    rst_n = 1'b1;
    @(negedge clk);
    check(!done && !x_inc && !rd_en && req_ready, "R10", "after reset",
          {28'b0, done, x_inc, rd_en, req_ready}, 32'h1);

    send(4'd0, 8'h34, 16'h0, 8'h00, 8'h00, 1'b0);   // R2
    send(4'd0, 8'h34, 16'h0, 8'h00, 8'h00, 1'b1);   // R2 page one
    send(4'd1, 8'hF0, 16'h0, 8'h20, 8'h00, 1'b1);   // R2 wrap in page
    send(4'd2, 8'hFF, 16'h0, 8'h00, 8'h01, 1'b0);   // R2 wrap in page
    send(4'd3, 8'h00, 16'h0, 8'h9A, 8'h11, 1'b1);   // R3
    send(4'd4, 8'h00, 16'h0, 8'h9A, 8'h11, 1'b0);   // R3
    send(4'd5, 8'h00, 16'h0, 8'hFF, 8'h00, 1'b1);   // R4
    send(4'd6, 8'h12, 16'hBEEF, 8'h01, 8'h02, 1'b1); // R5
    send(4'd7, 8'h00, 16'hFFF0, 8'h20, 8'h00, 1'b0); // R5 wrap
    send(4'd8, 8'h00, 16'h12F0, 8'h00, 8'h30, 1'b0); // R5 carry
    send(4'd9, 8'hFE, 16'h0, 8'h01, 8'h00, 1'b0);   // R6 high byte wraps
    send(4'd9, 8'h10, 16'h0, 8'h05, 8'h77, 1'b1);   // R6
    send(4'd10, 8'hFF, 16'h0, 8'h33, 8'h80, 1'b1);  // R7 high byte wraps
    send(4'd10, 8'h40, 16'h0, 8'h00, 8'hFF, 1'b0);  // R7
    send(4'd11, 8'h56, 16'h9999, 8'h01, 8'h01, 1'b1); // R9
    send(4'd15, 8'h57, 16'h9999, 8'h01, 8'h01, 1'b0); // R9
    for (int i = 0; i < 400; i++) begin
      send(4'($urandom_range(0, 15)), 8'($urandom), 16'($urandom),
           8'($urandom), 8'($urandom), 1'($urandom));
    end
    @(negedge clk);
    req_valid = 1'b0;
    repeat (8) @(negedge clk);
    check(exq.size() == 0 && rdq.size() == 0, "R8", "pending results",
          exq.size() + rdq.size(), 32'h0);
    finish_run();
  end

endmodule